// File: doc/BRIEF.md
# Two-Slot Instruction Prefetch Queue with Exception Injection

This block sits between instruction fetch and decode in a small 32-bit core with a three-stage fetch, decode and execute flow. It holds two prefetched words. Each word carries a 2-bit exception tag. Every cycle that is not a redirect is one advance step. In an advance step the queue:

- requests the word at the current fetch address;
- hands the oldest queued word to the issue output;
- stores the new word in the slot that was just emptied.

A failed fetch is not reported on a side path. The word is stored with an abort tag and travels down the queue like any other word.

Interrupts use the same path. When a fast or normal interrupt is requested and not masked, the queue overwrites its next-to-issue slot with the software-interrupt opcode 0xEF000000 and tags it with the interrupt kind. The interrupt is therefore taken at an instruction boundary. The issue side also provides a return address: the instruction that was displaced for an interrupt tag, and the following instruction otherwise.

A redirect restarts fetching at a new target. The queue spends two cycles refilling, with no valid issue, and then issues the target instruction.

Top module: `prefetch_inject_queue`

## Requirements
- R1: While reset is asserted, and in the first two cycles after it is released, issue_valid is 0. During reset, fetch_addr equals RESET_PC. The third cycle issues the word fetched at RESET_PC, visible after that cycle's clock edge.
- R2: In steady state fetch_addr advances by 4 each cycle. Words are issued one per cycle, in fetch order, with the opcode equal to the fetched data and tag 0 (none).
- R3: A word fetched while fetch_err is high is issued with its fetched opcode and tag 1 (abort).
- R4: issue_tag uses these codes: 0 none, 1 abort, 2 normal interrupt, 3 fast interrupt.
- R5: When fiq_req is high and fiq_mask is low in an advance cycle outside refill, the next word issued after the current one is opcode 0xEF000000 with tag 3. It keeps the address of the word it replaced.
- R6: The same holds for irq_req and irq_mask with tag 2, but only when no fast interrupt qualifies in that cycle. A fast interrupt wins when both qualify.
- R7: A request whose mask input is high injects nothing, and the queued word issues unchanged.
- R8: A cycle with redirect_valid high performs no advance. fetch_addr becomes redirect_addr and then redirect_addr+4 in the next two cycles, with issue_valid 0 after each of the three edges. The word at redirect_addr issues after the fourth edge.
- R9: Interrupt requests are ignored in a redirect cycle and during the two refill cycles. A request still held after the refill is injected.
- R10: issue_ret_pc equals issue_pc for tags 2 and 3, and issue_pc+4 for tags 0 and 1.
- R11: An injected word replaces exactly one queued word. The word issued after it is the one fetched 4 bytes above the replaced word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | output | AW | Address of the word fetched this cycle |
| fetch_data | input | DW | Word returned for fetch_addr in the same cycle |
| fetch_err | input | 1 | Fetch of fetch_addr failed this cycle |
| redirect_valid | input | 1 | Restart fetching at redirect_addr |
| redirect_addr | input | AW | New fetch target |
| fiq_req | input | 1 | Fast interrupt request |
| irq_req | input | 1 | Normal interrupt request |
| fiq_mask | input | 1 | Fast interrupt disabled |
| irq_mask | input | 1 | Normal interrupt disabled |
| issue_valid | output | 1 | Issue outputs hold an instruction |
| issue_opcode | output | DW | Issued opcode |
| issue_tag | output | 2 | Exception tag of the issued opcode |
| issue_pc | output | AW | Address the issued opcode belongs to |
| issue_ret_pc | output | AW | Return address for the exception the tag selects |

## Verification
The queue is driven through one long cycle-by-cycle sequence covering five cases:

- a plain linear stream, which shows the two slots alternate in fetch order;
- a fetch error on one word, which shows that only that word carries the abort tag;
- single and simultaneous interrupt requests, which separate the fast-over-normal priority and show the displaced word is dropped while its neighbour survives;
- masked requests, which check that the mask blocks injection;
- redirects with an interrupt held across the refill, which show refill suppression and the re-evaluation of the request once the refill ends.

A second redirect lands on the opposite active slot, so the order of issue cannot depend on which slot happens to be first. A mid-run reset confirms the return to the refill start.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum logic [1:0] {
        TAG_NONE  = 2'd0,
        TAG_ABORT = 2'd1,
        TAG_IRQ   = 2'd2,
        TAG_FIQ   = 2'd3
    } pfq_tag_e;

    // interrupt-class tags get the return-address adjustment
    function automatic logic tag_is_irq_class(logic [1:0] t);
        return t[1];
    endfunction

endpackage

// File: rtl/pfq_irq_arb.sv
module pfq_irq_arb
    import pfq_pkg::*;
(
    input  logic       redirect,
    input  logic       refilling,
    input  logic       fiq_req,
    input  logic       fiq_mask,
    input  logic       irq_req,
    input  logic       irq_mask,
    output logic       inject,
    output logic [1:0] inject_tag
);
    logic fiq_ok;
    logic irq_ok;

    always_comb begin
        fiq_ok     = fiq_req && !fiq_mask;
        irq_ok     = irq_req && !irq_mask;
        // redirect and refill both hold injection off
        inject     = !redirect && !refilling && (fiq_ok || irq_ok);
        inject_tag = fiq_ok ? TAG_FIQ : TAG_IRQ;
    end
endmodule

// File: rtl/pfq_ret_calc.sv
module pfq_ret_calc
    import pfq_pkg::*;
#(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] pc,
    input  logic [1:0]    tag,
    output logic [AW-1:0] ret_pc
);
    always_comb begin
        if (tag_is_irq_class(tag)) ret_pc = pc;
        else                       ret_pc = pc + AW'(STEP);
    end
endmodule

// File: rtl/prefetch_inject_queue.sv
module prefetch_inject_queue
    import pfq_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          DW       = 32,
    parameter logic [31:0] RESET_PC = 32'h0000_0100,
    parameter logic [31:0] SWI_OP   = 32'hEF00_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] fetch_addr,
    input  logic [DW-1:0] fetch_data,
    input  logic          fetch_err,
    input  logic          redirect_valid,
    input  logic [AW-1:0] redirect_addr,
    input  logic          fiq_req,
    input  logic          irq_req,
    input  logic          fiq_mask,
    input  logic          irq_mask,
    output logic          issue_valid,
    output logic [DW-1:0] issue_opcode,
    output logic [1:0]    issue_tag,
    output logic [AW-1:0] issue_pc,
    output logic [AW-1:0] issue_ret_pc
);
    localparam int SLOTS  = 2;
    localparam int STEP   = DW / 8;
    localparam int FILL_W = $clog2(SLOTS + 1);

    typedef struct packed {
        logic [SLOTS-1:0][DW-1:0] op;
        logic [SLOTS-1:0][1:0]    tag;
        logic [SLOTS-1:0][AW-1:0] pc;
        logic                     act;
        logic [FILL_W-1:0]        fill;
        logic [AW-1:0]            fpc;
        logic                     out_valid;
        logic [DW-1:0]            out_op;
        logic [1:0]               out_tag;
        logic [AW-1:0]            out_pc;
    } state_t;

    state_t st_q, st_d;
    logic       inject;
    logic [1:0] inject_tag;
    logic       adv_idx;
    logic       inj_idx;

    pfq_irq_arb u_arb (
        .redirect   (redirect_valid),
        .refilling  (st_q.fill != '0),
        .fiq_req    (fiq_req),
        .fiq_mask   (fiq_mask),
        .irq_req    (irq_req),
        .irq_mask   (irq_mask),
        .inject     (inject),
        .inject_tag (inject_tag)
    );

    pfq_ret_calc #(.AW(AW), .STEP(STEP)) u_ret (
        .pc     (st_q.out_pc),
        .tag    (st_q.out_tag),
        .ret_pc (issue_ret_pc)
    );

    always_comb begin
        st_d          = st_q;
        adv_idx       = st_q.act;
        inj_idx       = ~st_q.act;
        st_d.out_valid = 1'b0;
        if (redirect_valid) begin
            // no advance: restart fetching and begin a refill
            st_d.fpc  = redirect_addr;
            st_d.fill = FILL_W'(SLOTS);
        end else begin
            st_d.out_op        = st_q.op[adv_idx];
            st_d.out_tag       = st_q.tag[adv_idx];
            st_d.out_pc        = st_q.pc[adv_idx];
            st_d.out_valid     = (st_q.fill == '0);
            st_d.op[adv_idx]   = fetch_data;
            st_d.tag[adv_idx]  = fetch_err ? TAG_ABORT : TAG_NONE;
            st_d.pc[adv_idx]   = st_q.fpc;
            if (inject) begin
                // displaced word keeps its address for the return
                st_d.op[inj_idx]  = SWI_OP[DW-1:0];
                st_d.tag[inj_idx] = inject_tag;
            end
            st_d.act = ~st_q.act;
            st_d.fpc = st_q.fpc + AW'(STEP);
            if (st_q.fill != '0) st_d.fill = st_q.fill - FILL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.fill <= FILL_W'(SLOTS);
            st_q.fpc  <= RESET_PC[AW-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_addr   = st_q.fpc;
    assign issue_valid  = st_q.out_valid;
    assign issue_opcode = st_q.out_op;
    assign issue_tag    = st_q.out_tag;
    assign issue_pc     = st_q.out_pc;
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
    parameter int          AW     = 32,
    parameter int          DW     = 32,
    parameter logic [31:0] SWI_OP = 32'hEF00_0000
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] fetch_addr,
    input logic          redirect_valid,
    input logic [AW-1:0] redirect_addr,
    input logic          issue_valid,
    input logic [DW-1:0] issue_opcode,
    input logic [1:0]    issue_tag
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !issue_valid);

    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid |=> fetch_addr == $past(fetch_addr) + AW'(DW / 8));

    assert_redirect_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> fetch_addr == $past(redirect_addr));

    assert_redirect_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !issue_valid);

    assert_irq_tag_swi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_tag[1]) |-> issue_opcode == SWI_OP[DW-1:0]);
endmodule

bind prefetch_inject_queue pfq_checker #(.AW(AW), .DW(DW), .SWI_OP(SWI_OP)) u_pfq_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_addr     (fetch_addr),
    .redirect_valid (redirect_valid),
    .redirect_addr  (redirect_addr),
    .issue_valid    (issue_valid),
    .issue_opcode   (issue_opcode),
    .issue_tag      (issue_tag)
);

// File: tb/prefetch_inject_queue_bench.sv
module prefetch_inject_queue_bench;
    localparam int          PERIOD = 10;
    localparam logic [31:0] RST_PC = 32'h0000_0100;
    localparam logic [31:0] TGT    = 32'h0000_0200;
    localparam logic [31:0] SWI    = 32'hEF00_0000;
    localparam logic [31:0] SALT   = 32'h5A00_0000;
    localparam int          NV     = 25;

    // {redirect,fiq,irq,fiq_mask,irq_mask,err, exp_valid, exp_tag, exp_pc[11:0], exp_fetch[11:0]}
    localparam logic [32:0] VEC [NV] = '{
        {6'b000000, 1'b0, 2'd0, 12'h000, 12'h100}, // R1 refill
        {6'b000000, 1'b0, 2'd0, 12'h000, 12'h104}, // R1 refill
        {6'b000000, 1'b1, 2'd0, 12'h100, 12'h108}, // R1 first issue, R2
        {6'b000001, 1'b1, 2'd0, 12'h104, 12'h10C}, // R3 fetch error here
        {6'b000000, 1'b1, 2'd0, 12'h108, 12'h110}, // R2
        {6'b000000, 1'b1, 2'd1, 12'h10C, 12'h114}, // R3 R4 abort tag
        {6'b001000, 1'b1, 2'd0, 12'h110, 12'h118}, // R6 irq request
        {6'b000000, 1'b1, 2'd2, 12'h114, 12'h11C}, // R6 R10 injected
        {6'b011000, 1'b1, 2'd0, 12'h118, 12'h120}, // R5 R6 both requested, R11
        {6'b000000, 1'b1, 2'd3, 12'h11C, 12'h124}, // R5 fast wins
        {6'b011110, 1'b1, 2'd0, 12'h120, 12'h128}, // R7 both masked
        {6'b000000, 1'b1, 2'd0, 12'h124, 12'h12C}, // R7 no injection
        {6'b011100, 1'b1, 2'd0, 12'h128, 12'h130}, // R6 R7 fast masked
        {6'b000000, 1'b1, 2'd2, 12'h12C, 12'h134}, // R6
        {6'b110000, 1'b0, 2'd0, 12'h000, 12'h138}, // R8 R9 redirect beats fiq
        {6'b010000, 1'b0, 2'd0, 12'h000, 12'h200}, // R9 refill ignores fiq
        {6'b000000, 1'b0, 2'd0, 12'h000, 12'h204}, // R8 refill
        {6'b010000, 1'b1, 2'd0, 12'h200, 12'h208}, // R8 R9 fiq after refill
        {6'b000000, 1'b1, 2'd3, 12'h204, 12'h20C}, // R9 injected
        {6'b000000, 1'b1, 2'd0, 12'h208, 12'h210}, // R11 next word intact
        {6'b100001, 1'b0, 2'd0, 12'h000, 12'h214}, // R8 second redirect
        {6'b000000, 1'b0, 2'd0, 12'h000, 12'h200}, // R8
        {6'b000000, 1'b0, 2'd0, 12'h000, 12'h204}, // R8
        {6'b000000, 1'b1, 2'd0, 12'h200, 12'h208}, // R8 other active slot
        {6'b000000, 1'b1, 2'd0, 12'h204, 12'h20C}  // R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_addr;
    logic [31:0] fetch_data;
    logic        fetch_err = 1'b0;
    logic        redirect_valid = 1'b0;
    logic [31:0] redirect_addr = TGT;
    logic        fiq_req = 1'b0, irq_req = 1'b0, fiq_mask = 1'b0, irq_mask = 1'b0;
    logic        issue_valid;
    logic [31:0] issue_opcode;
    logic [1:0]  issue_tag;
    logic [31:0] issue_pc;
    logic [31:0] issue_ret_pc;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(PERIOD / 2) clk = ~clk;

    assign fetch_data = fetch_addr ^ SALT;

    prefetch_inject_queue #(.RESET_PC(RST_PC)) u_prefetch_inject_queue (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .fetch_err(fetch_err), .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .fiq_req(fiq_req), .irq_req(irq_req), .fiq_mask(fiq_mask), .irq_mask(irq_mask),
        .issue_valid(issue_valid), .issue_opcode(issue_opcode), .issue_tag(issue_tag),
        .issue_pc(issue_pc), .issue_ret_pc(issue_ret_pc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] t);
        case (t)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R6";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #(PERIOD * 4000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1 state during reset
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 valid in reset", {31'd0, issue_valid}, 32'd0);
        check("R1 fetch addr in reset", fetch_addr, RST_PC);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [32:0] v;
            logic [31:0] epc;
            logic [31:0] eop;
            logic [31:0] eret;
            v = VEC[i];
            redirect_valid = v[32];
            fiq_req   = v[31];
            irq_req   = v[30];
            fiq_mask  = v[29];
            irq_mask  = v[28];
            fetch_err = v[27];
            #1;
            check(v[32] ? "R8 fetch addr" : "R2 fetch addr", fetch_addr, {20'd0, v[11:0]});
            @(posedge clk);
            #1;
            check(v[26] ? "R1 issue valid" : "R8 issue valid", {31'd0, issue_valid}, {31'd0, v[26]});
            if (v[26]) begin
                epc  = {20'd0, v[23:12]};
                eop  = v[25] ? SWI : (epc ^ SALT);
                eret = v[25] ? epc : epc + 32'd4;
                check({req_of(v[25:24]), " R4 tag"}, {30'd0, issue_tag}, {30'd0, v[25:24]});
                check({req_of(v[25:24]), " pc"}, issue_pc, epc);
                check({req_of(v[25:24]), " opcode"}, issue_opcode, eop);
                check("R10 return pc", issue_ret_pc, eret);
            end
            @(negedge clk);
        end
        redirect_valid = 1'b0; fiq_req = 1'b0; irq_req = 1'b0;
        fiq_mask = 1'b0; irq_mask = 1'b0; fetch_err = 1'b0;

        // R1 mid-run reset returns to the refill start
        rst_n = 1'b0;
        #1;
        check("R1 valid after reset", {31'd0, issue_valid}, 32'd0);
        check("R1 fetch addr after reset", fetch_addr, RST_PC);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 refill cycle 1", {31'd0, issue_valid}, 32'd0);
        @(posedge clk); #1;
        check("R1 refill cycle 2", {31'd0, issue_valid}, 32'd0);
        @(posedge clk); #1;
        check("R1 first issue valid", {31'd0, issue_valid}, 32'd1);
        check("R1 first issue pc", issue_pc, RST_PC);
        check("R1 first issue opcode", issue_opcode, RST_PC ^ SALT);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule